// File: doc/BRIEF.md
# Lockstep Byte Handshake Bridge

This block joins a byte-wide USB FIFO device to a register port on a console expansion bus. When the block is idle, it takes one byte from the host receive FIFO and latches it. It then raises a strobe flag so the target knows a byte is waiting. The target reads the byte and then answers with one reply write. That write starts a fixed-length acknowledge pulse. No further byte is offered until the pulse has ended, so the two sides move strictly one byte for one reply.

The target can reply in two ways. A normal reply pushes its byte into the host transmit FIFO. A discard reply completes the handshake but stores nothing, so filler bytes never reach the host. A mode input chooses when a byte may be offered:
- **Paired mode:** a byte needs both a waiting host byte and free transmit space.
- **Free mode:** a byte needs only a waiting host byte, and transmit space is checked only when a normal reply is written.

Top module: `lockstep_bridge`

## Requirements
- R1: Synchronous active-low reset clears the strobe, the acknowledge, the held byte (an address 0 read returns 0x00) and returns the block to idle; no FIFO pop or push occurs while no host byte is waiting.
- R2: When idle and allowed by R3/R4, the block asserts `rx_pop` for one cycle, latches `rx_data`, and `stb` is high from the next cycle; host bytes reach the target in FIFO order.
- R3: With `free_mode` low, no byte is popped and `stb` stays low while `tx_ready` is low, even if `rx_valid` is high.
- R4: With `free_mode` high, a byte is popped and offered when `rx_valid` is high regardless of `tx_ready`.
- R5: A read at address 0 (cs and rd high, addr 0) returns the held byte and clears `stb`; a read at address 1 returns a status byte with bit 0 = `stb`, bit 1 = `tx_ready`, all other bits 0.
- R6: A write at address 0 after the byte was read is a normal reply: `tx_push` is high for exactly one cycle with `tx_data` equal to the written byte, and `ack` rises on the next cycle.
- R7: A write at address 1 after the byte was read is a discard reply: `ack` rises on the next cycle and no `tx_push` occurs.
- R8: `ack` stays high for exactly 4 consecutive cycles per reply; reply writes while it is high cause neither a push nor a lengthening of the pulse.
- R9: A reply write made while `stb` is still high (byte not yet read) is ignored, and no new byte is offered while `ack` is high.
- R10: A normal reply written while `tx_ready` is low is ignored: no push, no `ack`, and the block keeps waiting for a reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| free_mode | input | 1 | 1: offering ignores transmit space; 0: offering needs transmit space |
| rx_valid | input | 1 | Host receive FIFO holds a byte |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_pop | output | 1 | Remove the head byte from the receive FIFO |
| tx_ready | input | 1 | Host transmit FIFO has space |
| tx_data | output | 8 | Byte to push into the transmit FIFO |
| tx_push | output | 1 | Push `tx_data` into the transmit FIFO |
| cs | input | 1 | Target port select |
| rd | input | 1 | Target read |
| wr | input | 1 | Target write |
| addr | input | 1 | Target register select |
| wdata | input | 8 | Target write data |
| rdata | output | 8 | Target read data |
| stb | output | 1 | A host byte is waiting for the target |
| ack | output | 1 | Reply acknowledge pulse |

## Verification
The hardest situations to reach are replies that arrive at the wrong moment. These include a write before the byte is read, a write inside the acknowledge pulse, and a normal reply in free mode while the transmit FIFO is full. Each must leave the handshake untouched. The stimulus reaches them by holding the bus write at exactly those phases. It also feeds a second host byte early, so that a byte is already waiting while the pulse runs. A scoreboard of expected transmit bytes then shows that no stray push or early offer occurred.

// File: rtl/lsb_pkg.sv
// Shared definitions for the lockstep byte bridge.
// Assumes: a single clock domain; register select is one bit wide.
package lsb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // nothing latched, may pop a host byte
        ST_OFFER = 2'd1,   // byte latched, strobe raised
        ST_WAIT  = 2'd2,   // byte read, waiting for a reply write
        ST_ACK   = 2'd3    // acknowledge pulse running
    } lsb_state_e;

    localparam logic REG_DATA = 1'b0;  // byte / normal reply
    localparam logic REG_CTRL = 1'b1;  // status / discard reply
endpackage

// File: rtl/lsb_port_decode.sv
// Decodes target bus cycles into single-cycle events and muxes read data.
// Assumes: cs/rd/wr are synchronous and held for one cycle per access.
module lsb_port_decode
    import lsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] hold_q,
    input  logic              stb,
    input  logic              tx_ready,
    output logic              rd_byte,
    output logic              wr_reply,
    output logic              wr_discard,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - 2;

    logic [DATA_W-1:0] status;

    // Form access events from the select, strobe and address lines.
    always_comb begin
        rd_byte    = cs && rd && (addr == REG_DATA);
        wr_reply   = cs && wr && (addr == REG_DATA);
        wr_discard = cs && wr && (addr == REG_CTRL);
    end

    // Build the status byte and select read data by address.
    always_comb begin
        status = {{PAD_W{1'b0}}, tx_ready, stb};
        rdata  = (addr == REG_CTRL) ? status : hold_q;
    end
endmodule

// File: rtl/lsb_ack_timer.sv
// Generates a fixed-length acknowledge pulse and flags its last cycle.
// Assumes: start is ignored while a pulse is running.
module lsb_ack_timer #(
    parameter int ACK_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ack,
    output logic last
);
    localparam int CNT_W = (ACK_LEN > 1) ? $clog2(ACK_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(ACK_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count pulse cycles and drop the pulse after ACK_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            cnt_q <= '0;
        end else if (!ack) begin
            if (start) begin
                ack   <= 1'b1;
                cnt_q <= '0;
            end
        end else if (cnt_q == CNT_END) begin
            ack <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Mark the final cycle of the pulse.
    always_comb last = ack && (cnt_q == CNT_END);
endmodule

// File: rtl/lsb_ctrl.sv
// Handshake sequencer: latches one host byte, offers it, accepts one reply.
// Assumes: the transmit FIFO reports space through tx_ready without delay.
module lsb_ctrl
    import lsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              free_mode,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              tx_ready,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_byte,
    input  logic              wr_reply,
    input  logic              wr_discard,
    input  logic              ack_last,
    output logic              rx_pop,
    output logic              stb,
    output logic [DATA_W-1:0] hold_q,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    output logic              ack_start
);
    lsb_state_e state_q;
    logic       take_norm;
    logic       take_disc;

    // Decide on pops and accepted replies from the current state.
    always_comb begin
        rx_pop    = (state_q == ST_IDLE) && rx_valid && (free_mode || tx_ready);
        take_norm = (state_q == ST_WAIT) && wr_reply && tx_ready;
        take_disc = (state_q == ST_WAIT) && wr_discard;
        ack_start = take_norm || take_disc;
        tx_push   = take_norm;
        tx_data   = wdata;
        stb       = (state_q == ST_OFFER);
    end

    // Step through idle, offer, wait and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (rx_pop)    state_q <= ST_OFFER;
                ST_OFFER: if (rd_byte)   state_q <= ST_WAIT;
                ST_WAIT:  if (ack_start) state_q <= ST_ACK;
                ST_ACK:   if (ack_last)  state_q <= ST_IDLE;
                default:                 state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the host byte when it is popped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rx_pop) begin
            hold_q <= rx_data;
        end
    end
endmodule

// File: rtl/lockstep_bridge.sv
// Top of the lockstep byte bridge between a host byte FIFO pair and a
// target register port. Assumes one clock domain and synchronous bus lines.
module lockstep_bridge #(
    parameter int DATA_W  = 8,
    parameter int ACK_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              free_mode,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_pop,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_push,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              stb,
    output logic              ack
);
    logic [DATA_W-1:0] hold_q;
    logic              rd_byte;
    logic              wr_reply;
    logic              wr_discard;
    logic              ack_start;
    logic              ack_last;

    lsb_port_decode #(.DATA_W(DATA_W)) u_decode (
        .cs         (cs),
        .rd         (rd),
        .wr         (wr),
        .addr       (addr),
        .hold_q     (hold_q),
        .stb        (stb),
        .tx_ready   (tx_ready),
        .rd_byte    (rd_byte),
        .wr_reply   (wr_reply),
        .wr_discard (wr_discard),
        .rdata      (rdata)
    );

    lsb_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .free_mode  (free_mode),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .tx_ready   (tx_ready),
        .wdata      (wdata),
        .rd_byte    (rd_byte),
        .wr_reply   (wr_reply),
        .wr_discard (wr_discard),
        .ack_last   (ack_last),
        .rx_pop     (rx_pop),
        .stb        (stb),
        .hold_q     (hold_q),
        .tx_push    (tx_push),
        .tx_data    (tx_data),
        .ack_start  (ack_start)
    );

    lsb_ack_timer #(.ACK_LEN(ACK_LEN)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ack_start),
        .ack   (ack),
        .last  (ack_last)
    );
endmodule

// File: rtl/lockstep_bridge_chk.sv
// Port-level protocol checks for lockstep_bridge, attached by bind.
// Assumes: ACK_LEN small enough for a plain run counter.
module lockstep_bridge_chk #(
    parameter int DATA_W  = 8,
    parameter int ACK_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              free_mode,
    input logic              rx_valid,
    input logic              rx_pop,
    input logic              tx_ready,
    input logic              tx_push,
    input logic [DATA_W-1:0] rdata,
    input logic              stb,
    input logic              ack
);
    localparam int RUN_W = $clog2(ACK_LEN + 2) + 1;

    logic [RUN_W-1:0] run_q;

    // Count consecutive cycles with ack high.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= ack ? run_q + 1'b1 : '0;
    end

    p_pop_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_valid && !stb && !ack));

    p_stb_after_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> stb);

    p_pop_needs_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !free_mode) |-> tx_ready);

    p_push_then_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> (ack && !stb));

    p_ack_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (run_q < RUN_W'(ACK_LEN)));

    p_ack_full_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> (run_q == RUN_W'(ACK_LEN)));

    p_no_offer_in_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && ack));

    p_push_has_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> tx_ready);
endmodule

bind lockstep_bridge lockstep_bridge_chk #(.DATA_W(DATA_W), .ACK_LEN(ACK_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .free_mode (free_mode),
    .rx_valid  (rx_valid),
    .rx_pop    (rx_pop),
    .tx_ready  (tx_ready),
    .tx_push   (tx_push),
    .rdata     (rdata),
    .stb       (stb),
    .ack       (ack)
);

// File: tb/lockstep_bridge_bench.sv
// Scoreboard bench: bus tasks queue expected transmit bytes, a monitor
// compares pushes; a receive FIFO model feeds host bytes.
module lockstep_bridge_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       free_mode = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_pop;
    logic       tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       tx_push;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       stb, ack;

    int n_chk = 0, n_fail = 0, n_push = 0, n_pop = 0;
    int run_len = 0, last_run = 0, ack_runs = 0;
    bit pop_pending = 1'b0;
    bit finished = 1'b0;
    logic [7:0] rxq[$];
    logic [7:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lockstep_bridge u_lockstep_bridge (
        .clk(clk), .rst_n(rst_n), .free_mode(free_mode),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_push(tx_push),
        .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .stb(stb), .ack(ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compare pushes with the scoreboard, time ack pulses, note pops.
    always @(negedge clk) begin
        pop_pending = rx_pop;
        if (tx_push) begin
            n_push++;
            if (expq.size() == 0) check(1'b0, "R6 unexpected push", tx_data, 0);
            else begin
                logic [7:0] e;
                e = expq.pop_front();
                check(tx_data == e, "R6 push data", tx_data, e);
            end
        end
        if (ack) run_len++;
        else if (run_len != 0) begin
            last_run = run_len;
            run_len  = 0;
            ack_runs++;
        end
    end

    // Receive FIFO model: drop the head after a pop, present the next byte.
    always @(posedge clk) begin
        #1;
        if (pop_pending && rxq.size() > 0) begin
            void'(rxq.pop_front());
            n_pop++;
        end
        rx_valid = (rxq.size() > 0);
        rx_data  = (rxq.size() > 0) ? rxq[0] : 8'h00;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        tick();
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d, input bit expect_push);
        if (expect_push) expq.push_back(d);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        tick();
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic wait_stb(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 8 && !seen; i++) begin
            @(negedge clk);
            seen = stb;
        end
        check(seen, req, seen, 1);
        tick();
    endtask

    task automatic wait_ack_end();
        bit hi = 1'b1;
        for (int i = 0; i < 12 && hi; i++) begin
            @(negedge clk);
            hi = ack;
        end
        tick();
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        @(negedge clk);
        check(!stb && !ack && !rx_pop && !tx_push, "R1 outputs after reset",
              {stb, ack, rx_pop, tx_push}, 0);
        tick();
        bus_read(1'b0, d);
        check(d == 8'h00, "R1 held byte cleared", d, 0);

        // R3: paired mode, no transmit space -> nothing offered
        rxq.push_back(8'hA5);
        repeat (5) tick();
        @(negedge clk);
        check(!stb && n_pop == 0, "R3 no offer without tx space", stb, 0);
        tick();
        bus_read(1'b1, d);
        check(d == 8'h00, "R5 status idle", d, 8'h00);

        // R2: space appears -> byte offered
        tx_ready = 1'b1;
        wait_stb("R2 offer after space");
        check(n_pop == 1, "R2 single pop", n_pop, 1);
        // R9: reply before read is ignored
        bus_write(1'b0, 8'h11, 1'b0);
        @(negedge clk);
        check(!ack && stb, "R9 early reply ignored", {ack, stb}, 1);
        tick();
        bus_read(1'b1, d);
        check(d == 8'h03, "R5 status offering", d, 8'h03);
        bus_read(1'b0, d);
        check(d == 8'hA5, "R5 read held byte", d, 8'hA5);
        @(negedge clk);
        check(!stb, "R5 read clears stb", stb, 0);
        tick();
        rxq.push_back(8'hC3);
        // R6: normal reply with a write during the pulse (R8)
        bus_write(1'b0, 8'h5A, 1'b1);
        @(negedge clk);
        check(ack && !stb, "R6 ack after reply", {ack, stb}, 2);
        tick();
        bus_write(1'b0, 8'h77, 1'b0);
        @(negedge clk);
        check(!stb, "R9 no offer during ack", stb, 0);
        wait_ack_end();
        check(last_run == 4, "R8 ack length", last_run, 4);
        check(n_push == 1, "R8 write during ack ignored", n_push, 1);

        // R7: discard reply
        wait_stb("R2 second offer");
        bus_read(1'b0, d);
        check(d == 8'hC3, "R2 fifo order", d, 8'hC3);
        bus_write(1'b1, 8'hEE, 1'b0);
        @(negedge clk);
        check(ack, "R7 discard acks", ack, 1);
        wait_ack_end();
        check(n_push == 1 && last_run == 4 && ack_runs == 2, "R7 no push on discard",
              n_push, 1);

        // R4 / R10: free mode, transmit full
        free_mode = 1'b1;
        tx_ready  = 1'b0;
        rxq.push_back(8'h81);
        wait_stb("R4 offer without tx space");
        bus_read(1'b0, d);
        check(d == 8'h81, "R4 byte value", d, 8'h81);
        bus_write(1'b0, 8'h99, 1'b0);
        @(negedge clk);
        check(!ack && !stb, "R10 normal reply when full ignored", {ack, stb}, 0);
        tick();
        bus_write(1'b1, 8'h00, 1'b0);
        wait_ack_end();
        check(ack_runs == 3 && last_run == 4, "R10 discard still accepted", ack_runs, 3);

        // R2 / R4: burst of discarded replies
        rxq.push_back(8'h10);
        rxq.push_back(8'h20);
        rxq.push_back(8'h30);
        for (int i = 0; i < 3; i++) begin
            wait_stb("R4 burst offer");
            bus_read(1'b0, d);
            check(d == 8'h10 * (i + 1), "R2 burst order", d, 8'h10 * (i + 1));
            bus_write(1'b1, 8'h00, 1'b0);
            wait_ack_end();
        end

        // R6 in free mode with space
        tx_ready = 1'b1;
        rxq.push_back(8'h50);
        wait_stb("R4 offer with space");
        bus_read(1'b0, d);
        check(d == 8'h50, "R2 byte value", d, 8'h50);
        bus_write(1'b0, 8'h42, 1'b1);
        wait_ack_end();
        check(expq.size() == 0 && n_push == 2, "R6 scoreboard drained", n_push, 2);
        check(ack_runs == 7, "R8 pulse count", ack_runs, 7);
        finish_run();
    end
endmodule